// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Output Port

This block is the digital output side of a 16-bit sampling converter used in a three-wire daisy chain with no busy flag. A host raises the convert strobe while the serial clock is low. That edge starts a conversion and selects chain operation. An internal counter then times the conversion phase. During that phase the serial clock is ignored and the serial output stays low. When the phase ends, the result word is loaded into a shift register and its most significant bit appears on the serial output. The remaining bits leave on later serial-clock falling edges.

The serial input feeds the low end of the same shift register, sampled on each falling edge. Several devices wired output-to-input therefore behave as one long shift register. Once a device has sent its own word, it forwards what its upstream neighbour sent it. The convert strobe stays high through conversion and readback, and lowering it returns the port to acquisition. If the strobe rises while the serial clock is high, that is not a valid chain start: the port raises a fault flag and keeps its output low.

All port inputs are treated as already synchronous to the internal clock. A behavioural conversion stub supplies the result word together with a done strobe.

Top module: `daisy_chain_port`

## Requirements
- R1: After reset, `sdo` and `mode_err` are both low.
- R2: While no conversion or readback is active, `sdo` is low, including whenever `sdi` and `cnv` are both low.
- R3: A `cnv` rising edge seen while `sck` is low starts a conversion that lasts exactly CONV_CYCLES clock cycles, and `sdo` stays low throughout.
- R4: `sck` edges during the conversion phase do not shift data; the first bit after conversion is still the result MSB.
- R5: In the clock cycle after the last conversion cycle, `sdo` shows bit DATA_W-1 of the result word.
- R6: During readback, each `sck` falling edge (high in one sampled cycle, low in the next) shifts the word one place toward the MSB. `sdo` then shows the next lower result bit, and the `sdi` level sampled at that edge enters at bit 0.
- R7: After DATA_W falling edges, `sdo` carries the `sdi` bits in the order they were received, DATA_W edges later.
- R8: A `cnv` rising edge seen while `sck` is high raises `mode_err` from the next cycle and keeps `sdo` low until `cnv` falls.
- R9: One cycle after `cnv` is sampled low, `sdo` is low and `mode_err` is low, whatever phase was active; this also aborts a conversion in progress.
- R10: The word loaded is `conv_result` from the last cycle during the conversion in which `conv_done` was high. This includes the final conversion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the upstream device |
| conv_done | input | 1 | Result-valid strobe from the conversion stub |
| conv_result | input | DATA_W | Result word from the conversion stub |
| sdo | output | 1 | Serial data to the downstream device or host |
| mode_err | output | 1 | High while a start was seen with `sck` high |

## Verification
The bench builds the port with DATA_W of 16 and CONV_CYCLES reduced to 12. The short conversion lets `sck` toggling and two `conv_done` pulses both fall inside one conversion phase. A 32-edge readback then walks the result through, followed by a full word of upstream data. With these values, the abort of a conversion, a faulty start with `sck` high, and a pass-through delay of exactly one word can all be reached in a few hundred cycles.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_CONV  = 2'd1,
    ST_READ  = 2'd2,
    ST_FAULT = 2'd3
  } port_state_t;

  // true on the final cycle of a conversion phase of 'cycles' length
  function automatic logic conv_last(input int unsigned cnt, input int unsigned cycles);
    return cnt == cycles - 1;
  endfunction
endpackage

// File: rtl/dc_edge_detect.sv
module dc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cnv,
  input  logic sck,
  output logic cnv_rise,
  output logic sck_fall
);
  logic cnv_q;
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv;
      sck_q <= sck;
    end
  end

  assign cnv_rise = cnv & ~cnv_q;
  assign sck_fall = sck_q & ~sck;
endmodule

// File: rtl/dc_conv_timer.sv
module dc_conv_timer #(
  parameter int unsigned CYCLES = 20,
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  import daisy_pkg::*;

  logic [CNT_W-1:0] cnt;

  assign last = run & conv_last(int'(cnt), CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dc_shifter.sv
module dc_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] word, input logic b);
    return {word[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_word;
    end else if (shift) begin
      q <= shift_in(q, ser_in);
    end
  end
endmodule

// File: rtl/daisy_chain_port.sv
module daisy_chain_port #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  output logic              sdo,
  output logic              mode_err
);
  import daisy_pkg::*;

  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] pick_word(input logic done,
                                                  input logic [DATA_W-1:0] fresh,
                                                  input logic [DATA_W-1:0] held);
    return done ? fresh : held;
  endfunction

  port_state_t       state;
  logic              cnv_rise;
  logic              sck_fall;
  logic              in_conv;
  logic              timer_last;
  logic              conv_end;
  logic              do_shift;
  logic [DATA_W-1:0] held_word;
  logic [DATA_W-1:0] load_word;
  logic [DATA_W-1:0] shreg;

  dc_edge_detect u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv      (cnv),
    .sck      (sck),
    .cnv_rise (cnv_rise),
    .sck_fall (sck_fall)
  );

  assign in_conv = (state == ST_CONV);

  dc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_conv & cnv),
    .last  (timer_last)
  );

  assign conv_end  = in_conv & cnv & timer_last;
  assign do_shift  = (state == ST_READ) & cnv & sck_fall;
  assign load_word = pick_word(conv_done, conv_result, held_word);

  dc_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (conv_end),
    .load_word (load_word),
    .shift     (do_shift),
    .ser_in    (sdi),
    .q         (shreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_word <= '0;
    end else if (in_conv && conv_done) begin
      held_word <= conv_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ACQ;
    end else begin
      case (state)
        ST_ACQ: begin
          if (cnv_rise) state <= sck ? ST_FAULT : ST_CONV;
        end
        ST_CONV: begin
          if (!cnv)          state <= ST_ACQ;
          else if (conv_end) state <= ST_READ;
        end
        ST_READ, ST_FAULT: begin
          if (!cnv) state <= ST_ACQ;
        end
        default: state <= ST_ACQ;
      endcase
    end
  end

  assign sdo      = (state == ST_READ) & shreg[MSB];
  assign mode_err = (state == ST_FAULT);
endmodule

// File: rtl/daisy_chain_port_chk.sv
module daisy_chain_port_chk
  import daisy_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv,
  input logic              sck,
  input logic              sdi,
  input logic              sdo,
  input logic              mode_err,
  input port_state_t       state,
  input logic              in_conv,
  input logic              conv_end,
  input logic              cnv_rise,
  input logic              sck_fall,
  input logic [DATA_W-1:0] shreg,
  input logic [DATA_W-1:0] load_word
);
  int unsigned conv_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       conv_seen <= 0;
    else if (in_conv) conv_seen <= conv_seen + 1;
    else              conv_seen <= 0;
  end

  assert_conv_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |-> conv_seen == CONV_CYCLES - 1);

  assert_conv_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_conv |-> !sdo);

  assert_sck_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && !conv_end) |=> $stable(shreg));

  assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> sdo == $past(load_word[DATA_W-1]));

  assert_shift_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && cnv && sck_fall) |=>
      shreg == {$past(shreg[DATA_W-2:0]), $past(sdi)});

  assert_fault_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && cnv_rise && sck) |=> mode_err);

  assert_fault_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !sdo);

  assert_cnv_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv |=> (!sdo && !mode_err));
endmodule

bind daisy_chain_port daisy_chain_port_chk #(
  .DATA_W      (DATA_W),
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv       (cnv),
  .sck       (sck),
  .sdi       (sdi),
  .sdo       (sdo),
  .mode_err  (mode_err),
  .state     (state),
  .in_conv   (in_conv),
  .conv_end  (conv_end),
  .cnv_rise  (cnv_rise),
  .sck_fall  (sck_fall),
  .shreg     (shreg),
  .load_word (load_word)
);

// File: tb/daisy_chain_port_bench.sv
module daisy_chain_port_bench;
  localparam int DW = 16;
  localparam int CC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnv = 1'b0;
  logic          sck = 1'b0;
  logic          sdi = 1'b0;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_result = '0;
  logic          sdo;
  logic          mode_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  daisy_chain_port #(.DATA_W(DW), .CONV_CYCLES(CC)) u_daisy_chain_port (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .conv_done(conv_done), .conv_result(conv_result),
    .sdo(sdo), .mode_err(mode_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 converting, 2 reading, 3 fault
  int       m_mode = 0;
  int       m_cc = 0;
  bit       m_pc = 0, m_ps = 0;
  logic [DW-1:0] m_held = '0;
  bit       m_q[$];
  logic     exp_sdo = 0, exp_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cc = 0; m_pc = 0; m_ps = 0; m_held = '0; m_q = {};
    end else begin
      case (m_mode)
        0: if (cnv && !m_pc) begin m_mode = sck ? 3 : 1; m_cc = 0; end
        1: if (!cnv) m_mode = 0;
           else begin
             if (conv_done) m_held = conv_result;
             if (m_cc == CC - 1) begin
               m_q = {};
               for (int i = DW - 1; i >= 0; i--) m_q.push_back(m_held[i]);
               m_mode = 2;
             end else m_cc++;
           end
        2: if (!cnv) m_mode = 0;
           else if (m_ps && !sck) begin void'(m_q.pop_front()); m_q.push_back(sdi); end
        default: if (!cnv) m_mode = 0;
      endcase
      m_pc = cnv; m_ps = sck;
    end
    exp_sdo = (m_mode == 2) ? m_q[0] : 1'b0;
    exp_err = (m_mode == 3);
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      case (m_mode)
        0: check("R2 sdo", sdo, exp_sdo);
        1: check("R3 sdo", sdo, exp_sdo);
        2: check("R6 sdo", sdo, exp_sdo);
        default: check("R8 sdo", sdo, exp_sdo);
      endcase
      check("R8 mode_err", mode_err, exp_err);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one sck period; returns sdo seen just before the falling edge
  task automatic sck_pulse(input logic din, output logic seen);
    sck = 1'b1;
    wait_n(2);
    seen = sdo;
    sdi = din;
    sck = 1'b0;
    wait_n(2);
  endtask

  task automatic frame(input logic [DW-1:0] first, input logic [DW-1:0] last_word,
                       input bit two_pulses, input logic [DW-1:0] upstream,
                       input string tag);
    logic seen;
    logic [2*DW-1:0] got;
    @(negedge clk);
    sdi = 1'b0; sck = 1'b0; cnv = 1'b1;
    wait_n(1);
    check({tag, " R3 conv sdo low"}, sdo, 1'b0);
    sck = 1'b1; wait_n(1);
    conv_done = 1'b1; conv_result = two_pulses ? first : last_word; wait_n(1);
    conv_done = 1'b0; conv_result = '0;
    sck = 1'b0; wait_n(2);
    sck = 1'b1; wait_n(1);
    if (two_pulses) begin conv_done = 1'b1; conv_result = last_word; end
    wait_n(1);
    conv_done = 1'b0; sck = 1'b0;
    wait_n(CC - 7);
    check({tag, " R3 sdo low at last conv cycle"}, sdo, 1'b0);
    wait_n(1);
    check({tag, " R5 msb after conversion"}, sdo, last_word[DW-1]);
    for (int i = 0; i < 2 * DW; i++) begin
      sck_pulse((i < DW) ? upstream[DW-1-i] : 1'b0, seen);
      got[2*DW-1-i] = seen;
    end
    check({tag, " R4 R10 own word"}, got[2*DW-1:DW], last_word);
    check({tag, " R7 forwarded word"}, got[DW-1:0], upstream);
    cnv = 1'b0;
    wait_n(1);
    check({tag, " R9 sdo low after cnv low"}, sdo, 1'b0);
    wait_n(3);
  endtask

  initial begin
    logic seen;
    wait_n(3);
    check("R1 sdo reset", sdo, 1'b0);
    check("R1 mode_err reset", mode_err, 1'b0);
    rst_n = 1'b1;
    wait_n(3);
    sdi = 1'b1; wait_n(2);
    check("R2 sdo idle with sdi high", sdo, 1'b0);
    sdi = 1'b0;
    frame(16'h0000, 16'hB3C5, 1'b0, 16'h5A0F, "f1");
    frame(16'hFFFF, 16'h8001, 1'b1, 16'hC3A5, "f2 R10");
    frame(16'h1234, 16'h7FFE, 1'b0, 16'hFFFF, "f3");
    // fault start
    sck = 1'b1; wait_n(1);
    cnv = 1'b1; wait_n(2);
    check("R8 mode_err set", mode_err, 1'b1);
    for (int i = 0; i < 4; i++) sck_pulse(1'b1, seen);
    check("R8 sdo low in fault", sdo, 1'b0);
    cnv = 1'b0; wait_n(1);
    check("R9 mode_err cleared", mode_err, 1'b0);
    wait_n(3);
    // aborted conversion
    cnv = 1'b1; conv_done = 1'b1; conv_result = 16'hFFFF; wait_n(3);
    conv_done = 1'b0; wait_n(2);
    cnv = 1'b0; wait_n(CC + 4);
    check("R9 abort keeps sdo low", sdo, 1'b0);
    frame(16'h0000, 16'hA5A5, 1'b0, 16'h0F0F, "f4");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule